// File: doc/BRIEF.md
# Two-Bank SDRAM Command and Bank-State Tracker

This block models the device side of a synchronous DRAM interface. On every rising clock edge with clock enable high it decodes the active-low command pins into one of six operations. The operations are row activate, column write, column read, bank close, refresh and mode load. It keeps an open/closed flag and a latched row for each of its two banks. Reads and writes run as bursts against a small behavioural storage array, with per-byte masking. Read data comes back after a programmable latency.

A mode load selects the burst length and the read latency. An illegal command is dropped and raises a one-cycle error flag. The illegal cases are an access to a closed bank, an access before the first mode load, an activate of an already open bank, and a refresh or mode load while any bank is open. Refresh commands alternate between the banks. Clock enable low at an edge freezes everything, including a burst part way through.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After reset both banks are closed, no mode is loaded, `err` is 0, `dq_oe` is 0 and `ref_next` is 0.
- R2: Pins {cs_n,ras_n,cas_n,we_n} decode as 0011 activate, 0101 read, 0100 write, 0010 close, 0001 refresh, 0000 mode load. `addr[11]` selects the bank, `addr[1:0]` is the row on activate and `addr[2:0]` is the column on read or write. Each bank keeps its own row and data.
- R3: A read or write to a closed bank, or issued before the first mode load, sets `err` for the next cycle and neither stores nor returns data.
- R4: Mode load takes the burst length from `addr[1:0]` (0:1, 1:2, 2:4, 3:8 beats) and the latency from `addr[2]` (0:2, 1:3 cycles). It is accepted only when both banks are closed; otherwise `err` is set and the load is ignored.
- R5: A write burst stores `dq_in` at the command edge and at each following enabled edge. The columns are start, start+1 and so on, wrapping modulo 8 within the same bank and row.
- R6: Beat k of a read burst is visible on `dq_out` with `dq_oe` high during the cycle after the (L+k)-th enabled edge following the command edge, where L is the latency. `dq_oe` is 0 outside the burst.
- R7: A write beat with `dqm[b]` high leaves byte b (`dqm[0]` covers bits 7:0) of the stored word unchanged.
- R8: A read beat fetched at an edge where `dqm[b]` is high comes out with `dq_oe[b]` low and that byte of `dq_out` zero.
- R9: An edge with `cke` low is ignored. The command is dropped, no data is stored, and bank state, burst progress, read pipeline and outputs all hold.
- R10: With `cs_n` high no command is taken and no error is raised, but a running burst continues.
- R11: A close command with `addr[10]` low closes the bank at `addr[11]`, and with `addr[10]` high closes both. A burst to a closed bank stops at that edge, so that beat is not performed.
- R12: A legal refresh toggles `ref_next` (the bank the next refresh targets, 0 after reset). A refresh with any bank open sets `err` and leaves `ref_next` unchanged.
- R13: An activate of an already open bank sets `err` and keeps the previously latched row.
- R14: A legal read or write issued during a burst ends the old burst and starts the new one at that edge. Read beats already fetched still come out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable; low suppresses the edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 2 | Per-byte data mask |
| addr | input | 12 | Row, column, bank and mode bits |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-byte read drive enable |
| err | output | 1 | Protocol error flag, one cycle after the offending edge |
| ref_next | output | 1 | Bank the next refresh targets |

## Verification
The properties assume that the command pins, `cke` and `addr` carry known values on every edge once reset is released, and that reset is held for at least one edge at start-up. The bench drives all inputs from tasks on the falling edge, keeps the pins at a defined deselect pattern during reset, and never leaves them undriven. It only reads back columns it has written earlier, so every expected read value comes from its own shadow copy of the array.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    localparam int NUM_BANKS = 2;
    localparam int LAT_LO    = 2;
    localparam int LAT_HI    = 3;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_MODE
    } cmd_e;

    typedef struct packed {
        logic [1:0] len_code;   // beats = 1 << len_code
        logic       lat3;       // 1: three-cycle read latency
    } mode_t;

    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e c;
        c = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                3'b000:  c = CMD_MODE;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic [3:0] beats_of(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/sdt_bank_ctrl.sv
module sdt_bank_ctrl
    import sdt_pkg::*;
#(
    parameter int ROW_BITS = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               en,
    input  cmd_e                               cmd,
    input  logic                               bank,
    input  logic                               all_banks,
    input  logic [ROW_BITS-1:0]                row_in,
    input  logic [2:0]                         mode_bits,
    output logic [NUM_BANKS-1:0]               open_q,
    output logic [NUM_BANKS-1:0][ROW_BITS-1:0] row_q,
    output mode_t                              mode_q,
    output logic                               acc_ok,
    output logic [NUM_BANKS-1:0]               pre_mask,
    output logic                               ref_ptr,
    output logic                               err_q
);

    logic mode_ok;
    logic is_acc;
    logic any_open;
    logic bad;

    always_comb begin
        is_acc   = (cmd == CMD_RD) || (cmd == CMD_WR);
        any_open = |open_q;
        acc_ok   = is_acc && mode_ok && open_q[bank];
        bad      = (is_acc && !acc_ok)
                 || ((cmd == CMD_ACT) && open_q[bank])
                 || (((cmd == CMD_REF) || (cmd == CMD_MODE)) && any_open);
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign pre_mask[b] = (cmd == CMD_PRE) && (all_banks || (int'(bank) == b));

            always_ff @(posedge clk) begin
                if (rst) begin
                    open_q[b] <= 1'b0;
                    row_q[b]  <= '0;
                end else if (en) begin
                    if ((cmd == CMD_ACT) && (int'(bank) == b) && !open_q[b]) begin
                        open_q[b] <= 1'b1;
                        row_q[b]  <= row_in;
                    end else if (pre_mask[b]) begin
                        open_q[b] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            mode_ok <= 1'b0;
            ref_ptr <= 1'b0;
            err_q   <= 1'b0;
        end else if (en) begin
            err_q <= bad;
            if ((cmd == CMD_MODE) && !any_open) begin
                mode_q.len_code <= mode_bits[1:0];
                mode_q.lat3     <= mode_bits[2];
                mode_ok         <= 1'b1;
            end
            if ((cmd == CMD_REF) && !any_open)
                ref_ptr <= ~ref_ptr;
        end
    end

endmodule

// File: rtl/sdt_burst.sv
module sdt_burst
    import sdt_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 3,
    localparam int AW      = 1 + ROW_BITS + COL_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 start,
    input  logic                 start_wr,
    input  logic                 bank,
    input  logic [ROW_BITS-1:0]  row,
    input  logic [COL_BITS-1:0]  col,
    input  logic [3:0]           len,
    input  logic [NUM_BANKS-1:0] stop_mask,
    output logic                 beat_valid,
    output logic                 beat_wr,
    output logic [AW-1:0]        beat_addr
);

    logic                act_q;
    logic                wr_q;
    logic                bank_q;
    logic [ROW_BITS-1:0] row_q;
    logic [COL_BITS-1:0] col_q;
    logic [3:0]          left_q;   // beats still to issue
    logic                run;

    always_comb begin
        run = act_q && !stop_mask[bank_q];
        if (start) begin
            beat_valid = 1'b1;
            beat_wr    = start_wr;
            beat_addr  = {bank, row, col};
        end else begin
            beat_valid = run;
            beat_wr    = run && wr_q;
            beat_addr  = {bank_q, row_q, col_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            wr_q   <= 1'b0;
            bank_q <= 1'b0;
            row_q  <= '0;
            col_q  <= '0;
            left_q <= '0;
        end else if (en) begin
            if (start) begin
                act_q  <= (len != 4'd1);
                wr_q   <= start_wr;
                bank_q <= bank;
                row_q  <= row;
                col_q  <= col + COL_BITS'(1);
                left_q <= len - 4'd1;
            end else if (run) begin
                act_q  <= (left_q > 4'd1);
                col_q  <= col_q + COL_BITS'(1);
                left_q <= left_q - 4'd1;
            end else begin
                act_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdt_store.sv
module sdt_store #(
    parameter int DATA_W = 16,
    parameter int AW     = 6,
    localparam int BYTES = DATA_W / 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [BYTES-1:0]  wmask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) begin
            for (int b = 0; b < BYTES; b++) begin
                if (!wmask[b])
                    mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
            end
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/sdt_rd_pipe.sv
module sdt_rd_pipe
    import sdt_pkg::*;
#(
    parameter int DATA_W  = 16,
    localparam int BYTES  = DATA_W / 8,
    localparam int STAGES = LAT_HI + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              lat3,
    input  logic              in_valid,
    input  logic [BYTES-1:0]  in_mask,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [BYTES-1:0]  dq_oe
);

    logic [STAGES-1:0]             v_q;
    logic [STAGES-1:0][BYTES-1:0]  m_q;
    logic [STAGES-1:0][DATA_W-1:0] d_q;
    int                            sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
            m_q <= '0;
            d_q <= '0;
        end else if (en) begin
            v_q <= {v_q[STAGES-2:0], in_valid};
            m_q <= {m_q[STAGES-2:0], in_mask};
            d_q <= {d_q[STAGES-2:0], in_data};
        end
    end

    always_comb begin
        sel = lat3 ? LAT_HI : LAT_LO;
        for (int b = 0; b < BYTES; b++) begin
            dq_oe[b]          = v_q[sel] && !m_q[sel][b];
            dq_out[b*8 +: 8]  = dq_oe[b] ? d_q[sel][b*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdt_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 12,
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 3,
    localparam int BYTES    = DATA_W / 8,
    localparam int BANK_BIT = ADDR_W - 1,
    localparam int ALL_BIT  = ADDR_W - 2,
    localparam int AW       = 1 + ROW_BITS + COL_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BYTES-1:0]  dqm,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [BYTES-1:0]  dq_oe,
    output logic              err,
    output logic              ref_next
);

    cmd_e                               cmd;
    logic                               bank;
    logic [NUM_BANKS-1:0]               open_q;
    logic [NUM_BANKS-1:0][ROW_BITS-1:0] row_q;
    mode_t                              mode_q;
    logic                               acc_ok;
    logic [NUM_BANKS-1:0]               pre_mask;
    logic                               beat_valid;
    logic                               beat_wr;
    logic [AW-1:0]                      beat_addr;
    logic [DATA_W-1:0]                  rdata;

    assign cmd  = decode_pins(cs_n, ras_n, cas_n, we_n);
    assign bank = addr[BANK_BIT];

    sdt_bank_ctrl #(.ROW_BITS(ROW_BITS)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .en        (cke),
        .cmd       (cmd),
        .bank      (bank),
        .all_banks (addr[ALL_BIT]),
        .row_in    (addr[ROW_BITS-1:0]),
        .mode_bits (addr[2:0]),
        .open_q    (open_q),
        .row_q     (row_q),
        .mode_q    (mode_q),
        .acc_ok    (acc_ok),
        .pre_mask  (pre_mask),
        .ref_ptr   (ref_next),
        .err_q     (err)
    );

    sdt_burst #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_burst (
        .clk        (clk),
        .rst        (rst),
        .en         (cke),
        .start      (acc_ok),
        .start_wr   (cmd == CMD_WR),
        .bank       (bank),
        .row        (row_q[bank]),
        .col        (addr[COL_BITS-1:0]),
        .len        (beats_of(mode_q.len_code)),
        .stop_mask  (pre_mask),
        .beat_valid (beat_valid),
        .beat_wr    (beat_wr),
        .beat_addr  (beat_addr)
    );

    sdt_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
        .clk   (clk),
        .en    (cke),
        .we    (beat_valid && beat_wr),
        .addr  (beat_addr),
        .wmask (dqm),
        .wdata (dq_in),
        .rdata (rdata)
    );

    sdt_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .en       (cke),
        .lat3     (mode_q.lat3),
        .in_valid (beat_valid && !beat_wr),
        .in_mask  (dqm),
        .in_data  (rdata),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

endmodule

// File: rtl/sdram_bank_tracker_chk.sv
module sdram_bank_tracker_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    localparam int BYTES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] dq_out,
    input logic [BYTES-1:0]  dq_oe,
    input logic              err,
    input logic              ref_next,
    input logic [1:0]        bank_open
);

    logic [3:0] pins;
    logic       is_acc;
    logic       sel;

    assign pins   = {cs_n, ras_n, cas_n, we_n};
    assign is_acc = (pins == 4'b0101) || (pins == 4'b0100);
    assign sel    = addr[ADDR_W-1];

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!err && (dq_oe == '0) && !ref_next));

    a_r3_closed_access_flags: assert property (@(posedge clk) disable iff (rst)
        (cke && is_acc && !bank_open[sel]) |=> err);

    a_r9_frozen_edge: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ($stable(dq_out) && $stable(dq_oe) && $stable(err)
                  && $stable(ref_next) && $stable(bank_open)));

    a_r10_deselect_no_error: assert property (@(posedge clk) disable iff (rst)
        (cke && cs_n) |=> !err);

    a_r12_refresh_toggles: assert property (@(posedge clk) disable iff (rst)
        (cke && (pins == 4'b0001) && (bank_open == 2'b00))
        |=> (!err && (ref_next != $past(ref_next))));

    a_r13_double_activate: assert property (@(posedge clk) disable iff (rst)
        (cke && (pins == 4'b0011) && bank_open[sel]) |=> err);

endmodule

bind sdram_bank_tracker sdram_bank_tracker_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .err       (err),
    .ref_next  (ref_next),
    .bank_open (open_q)
);

// File: tb/tb_sdram_bank_tracker.sv
`timescale 1ns/1ps
module tb_sdram_bank_tracker;

    localparam logic [3:0] P_DES  = 4'b1111;
    localparam logic [3:0] P_NOP  = 4'b0111;
    localparam logic [3:0] P_ACT  = 4'b0011;
    localparam logic [3:0] P_RD   = 4'b0101;
    localparam logic [3:0] P_WR   = 4'b0100;
    localparam logic [3:0] P_PRE  = 4'b0010;
    localparam logic [3:0] P_REF  = 4'b0001;
    localparam logic [3:0] P_MODE = 4'b0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cke;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  dqm;
    logic [11:0] addr;
    logic [15:0] dq_in;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        err;
    logic        ref_next;

    int   vecs = 0;
    int   fails = 0;
    bit   done = 1'b0;
    int   bl_tb = 1;
    int   cl_tb = 2;
    logic [15:0] model [2][4][8];

    always #4 clk = ~clk;

    sdram_bank_tracker dut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dqm(dqm), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .err(err), .ref_next(ref_next)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] p, input logic [11:0] a, input logic [1:0] m,
                        input logic [15:0] d, input logic ce);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = p;
        addr = a; dqm = m; dq_in = d; cke = ce;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();
        step(P_NOP, 12'h000, 2'b00, 16'h0000, 1'b1);
    endtask

    task automatic act(input logic bk, input logic [1:0] rw);
        step(P_ACT, {bk, 9'h000, rw}, 2'b00, 16'h0000, 1'b1);
    endtask

    task automatic close_all();
        step(P_PRE, 12'h400, 2'b00, 16'h0000, 1'b1);
    endtask

    task automatic set_mode(input logic [1:0] code, input logic l3);
        step(P_MODE, {9'h000, l3, code}, 2'b00, 16'h0000, 1'b1);
        bl_tb = 1 << code;
        cl_tb = l3 ? 3 : 2;
    endtask

    task automatic remode(input logic [1:0] code, input logic l3);
        close_all();
        set_mode(code, l3);
        chk("R4 mode accepted", {31'b0, err}, 0);
        act(1'b0, 2'd1);
        act(1'b1, 2'd2);
    endtask

    task automatic wr_burst(input logic bk, input logic [1:0] rw, input logic [2:0] col,
                            input logic [15:0] base, input logic [1:0] m);
        for (int k = 0; k < bl_tb; k++) begin
            logic [2:0]  c = 3'(col + k);
            logic [15:0] d = base + 16'(k);
            step((k == 0) ? P_WR : P_NOP, {bk, 8'h00, col}, m, d, 1'b1);
            if (!m[0]) model[bk][rw][c][7:0]  = d[7:0];
            if (!m[1]) model[bk][rw][c][15:8] = d[15:8];
        end
    endtask

    task automatic rd_burst(input string req, input logic bk, input logic [1:0] rw,
                            input logic [2:0] col, input logic [3:0] fol);
        step(P_RD, {bk, 8'h00, col}, 2'b00, 16'h0000, 1'b1);
        chk(req, {31'b0, err}, 0);
        for (int t = 1; t < cl_tb; t++) begin
            step(fol, 12'h000, 2'b00, 16'h0000, 1'b1);
            chk({req, " latency idle"}, {30'b0, dq_oe}, 0);
        end
        for (int k = 0; k < bl_tb; k++) begin
            step(fol, 12'h000, 2'b00, 16'h0000, 1'b1);
            chk(req, {14'b0, dq_oe, dq_out}, {14'b0, 2'b11, model[bk][rw][3'(col + k)]});
        end
        step(fol, 12'h000, 2'b00, 16'h0000, 1'b1);
        chk({req, " burst end"}, {30'b0, dq_oe}, 0);
    endtask

    task automatic t_reset();
        chk("R1 err", {31'b0, err}, 0);
        chk("R1 oe", {30'b0, dq_oe}, 0);
        chk("R1 ref_next", {31'b0, ref_next}, 0);
    endtask

    task automatic t_early();
        act(1'b0, 2'd1);
        step(P_RD, 12'h000, 2'b00, 16'h0000, 1'b1);
        chk("R3 access before mode", {31'b0, err}, 1);
        for (int i = 0; i < 4; i++) begin
            nop();
            chk("R3 no read data", {30'b0, dq_oe}, 0);
        end
        set_mode(2'd3, 1'b0);
        chk("R4 mode with open bank", {31'b0, err}, 1);
        close_all();
        chk("R4 err clears", {31'b0, err}, 0);
        set_mode(2'd3, 1'b0);
        chk("R4 mode accepted", {31'b0, err}, 0);
        step(P_RD, 12'h800, 2'b00, 16'h0000, 1'b1);
        chk("R3 closed bank", {31'b0, err}, 1);
        for (int i = 0; i < 4; i++) begin
            nop();
            chk("R3 closed bank no data", {30'b0, dq_oe}, 0);
        end
    endtask

    task automatic t_fill();
        act(1'b0, 2'd3);
        wr_burst(1'b0, 2'd3, 3'd0, 16'h3000, 2'b00);
        close_all();
        act(1'b0, 2'd1);
        act(1'b1, 2'd2);
        wr_burst(1'b0, 2'd1, 3'd0, 16'h1000, 2'b00);
        wr_burst(1'b1, 2'd2, 3'd0, 16'h2000, 2'b00);
        chk("R2 writes legal", {31'b0, err}, 0);
        rd_burst("R2 bank0", 1'b0, 2'd1, 3'd0, P_NOP);
        rd_burst("R2 bank1", 1'b1, 2'd2, 3'd0, P_NOP);
    endtask

    task automatic t_wrap();
        remode(2'd2, 1'b0);
        wr_burst(1'b0, 2'd1, 3'd6, 16'h1600, 2'b00);
        rd_burst("R5 wrap", 1'b0, 2'd1, 3'd6, P_NOP);
        rd_burst("R6 latency2", 1'b1, 2'd2, 3'd4, P_NOP);
        remode(2'd2, 1'b1);
        rd_burst("R6 latency3", 1'b1, 2'd2, 3'd5, P_NOP);
        remode(2'd1, 1'b0);
        rd_burst("R4 length2", 1'b0, 2'd1, 3'd3, P_NOP);
    endtask

    task automatic t_wmask();
        remode(2'd0, 1'b0);
        wr_burst(1'b0, 2'd1, 3'd2, 16'hABCD, 2'b01);
        rd_burst("R7 masked low byte", 1'b0, 2'd1, 3'd2, P_NOP);
        wr_burst(1'b1, 2'd2, 3'd3, 16'h5E7A, 2'b10);
        rd_burst("R7 masked high byte", 1'b1, 2'd2, 3'd3, P_NOP);
    endtask

    task automatic t_rmask();
        logic [15:0] w0, w1;
        remode(2'd1, 1'b0);
        w0 = model[0][1][4];
        w1 = model[0][1][5];
        step(P_RD, 12'h004, 2'b10, 16'h0000, 1'b1);
        step(P_NOP, 12'h000, 2'b01, 16'h0000, 1'b1);
        step(P_NOP, 12'h000, 2'b00, 16'h0000, 1'b1);
        chk("R8 beat0 high masked", {14'b0, dq_oe, dq_out}, {14'b0, 2'b01, 8'h00, w0[7:0]});
        nop();
        chk("R8 beat1 low masked", {14'b0, dq_oe, dq_out}, {14'b0, 2'b10, w1[15:8], 8'h00});
        nop();
        chk("R8 end", {30'b0, dq_oe}, 0);
    endtask

    task automatic t_cke();
        remode(2'd2, 1'b0);
        step(P_RD, 12'h000, 2'b00, 16'h0000, 1'b1);
        nop();
        nop();
        chk("R9 beat0", {14'b0, dq_oe, dq_out}, {14'b0, 2'b11, model[0][1][0]});
        step(P_RD, 12'h004, 2'b00, 16'h0000, 1'b0);
        chk("R9 hold data", {14'b0, dq_oe, dq_out}, {14'b0, 2'b11, model[0][1][0]});
        step(P_WR, 12'h000, 2'b00, 16'hFFFF, 1'b0);
        chk("R9 hold data", {14'b0, dq_oe, dq_out}, {14'b0, 2'b11, model[0][1][0]});
        chk("R9 no error", {31'b0, err}, 0);
        for (int k = 1; k < 4; k++) begin
            nop();
            chk("R9 resumed beat", {14'b0, dq_oe, dq_out}, {14'b0, 2'b11, model[0][1][k]});
        end
        nop();
        chk("R9 burst end", {30'b0, dq_oe}, 0);
    endtask

    task automatic t_desel();
        rd_burst("R10 deselect continues", 1'b0, 2'd1, 3'd0, 4'b1000);
        chk("R10 no error", {31'b0, err}, 0);
    endtask

    task automatic t_pre();
        step(P_WR, 12'h004, 2'b00, 16'h4440, 1'b1);
        model[0][1][4] = 16'h4440;
        step(P_NOP, 12'h000, 2'b00, 16'h4441, 1'b1);
        model[0][1][5] = 16'h4441;
        step(P_PRE, 12'h000, 2'b00, 16'h4442, 1'b1);
        step(P_NOP, 12'h000, 2'b00, 16'h4443, 1'b1);
        act(1'b0, 2'd1);
        rd_burst("R11 burst stopped", 1'b0, 2'd1, 3'd4, P_NOP);
        step(P_PRE, 12'h800, 2'b00, 16'h0000, 1'b1);
        step(P_RD, 12'h000, 2'b00, 16'h0000, 1'b1);
        chk("R11 other bank still open", {31'b0, err}, 0);
        step(P_RD, 12'h800, 2'b00, 16'h0000, 1'b1);
        chk("R11 single close", {31'b0, err}, 1);
        act(1'b1, 2'd2);
        close_all();
        step(P_RD, 12'h000, 2'b00, 16'h0000, 1'b1);
        chk("R11 close all bank0", {31'b0, err}, 1);
        step(P_RD, 12'h800, 2'b00, 16'h0000, 1'b1);
        chk("R11 close all bank1", {31'b0, err}, 1);
        for (int i = 0; i < 6; i++) nop();
    endtask

    task automatic t_ref();
        chk("R12 start bank", {31'b0, ref_next}, 0);
        step(P_REF, 12'h000, 2'b00, 16'h0000, 1'b1);
        chk("R12 legal", {31'b0, err}, 0);
        chk("R12 toggle", {31'b0, ref_next}, 1);
        step(P_REF, 12'h000, 2'b00, 16'h0000, 1'b1);
        chk("R12 toggle back", {31'b0, ref_next}, 0);
        act(1'b1, 2'd2);
        step(P_REF, 12'h000, 2'b00, 16'h0000, 1'b1);
        chk("R12 refresh open bank", {31'b0, err}, 1);
        chk("R12 pointer held", {31'b0, ref_next}, 0);
        close_all();
    endtask

    task automatic t_act_open();
        act(1'b0, 2'd1);
        act(1'b0, 2'd3);
        chk("R13 double activate", {31'b0, err}, 1);
        rd_burst("R13 row kept", 1'b0, 2'd1, 3'd0, P_NOP);
    endtask

    task automatic t_replace();
        step(P_RD, 12'h000, 2'b00, 16'h0000, 1'b1);
        nop();
        step(P_RD, 12'h004, 2'b00, 16'h0000, 1'b1);
        chk("R14 old beat0", {14'b0, dq_oe, dq_out}, {14'b0, 2'b11, model[0][1][0]});
        nop();
        chk("R14 old beat1", {14'b0, dq_oe, dq_out}, {14'b0, 2'b11, model[0][1][1]});
        for (int k = 4; k < 8; k++) begin
            nop();
            chk("R14 new burst", {14'b0, dq_oe, dq_out}, {14'b0, 2'b11, model[0][1][k]});
        end
        nop();
        chk("R14 end", {30'b0, dq_oe}, 0);
    endtask

    initial begin
        rst = 1'b1; cke = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = P_DES;
        addr = '0; dqm = '0; dq_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_early();
        t_fill();
        t_wrap();
        t_wmask();
        t_rmask();
        t_cke();
        t_desel();
        t_pre();
        t_ref();
        t_act_open();
        t_replace();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vecs++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

endmodule